// File: doc/BRIEF.md
# Fixed Off-Time Current Chopper

This block regulates winding current in the power stage of a three-phase motor drive. In chopping mode, an over-current comparator flag turns the upper driver off. The upper driver then stays off for a fixed, programmable number of clock cycles, and after that it is switched back on. Each time it comes back on, a blanking window follows. During that window the comparator is ignored, so the current spike at turn-on cannot start a new off-time at once. Only the upper driver is chopped. The lower driver of the active phase stays on, and the commutation logic outside this block drives it.

A second flag comes from an analog compare outside the block. It goes high when the linear current reference is below the chopping reference. While that flag is high, the block is in linear mode. In linear mode it does not chop, it keeps the upper enable asserted, and it asks for slow output edges. When the flag falls, chopping starts again with a fresh blanking window. Both flags are asynchronous, and each passes through a two-flop synchronizer. The off-time count and the blanking count are static configuration inputs. A count of zero behaves as one cycle.

Top module: `offtime_chopper`

## Requirements
- R1: While reset is held and right after it, `upper_en_o` is 1, `lin_mode_o` is 0 and `slew_fast_o` is 1. A blanking window of max(`blank_cnt_i`,1) cycles follows reset release. With `trip_i` held high from release, `upper_en_o` first reads 0 after clock edge max(`blank_cnt_i`,1)+1.
- R2: In chopping mode, with blanking over, a rising `trip_i` makes `upper_en_o` read 0 after the third rising clock edge. The edges are: synchronizer stage one, stage two, then the state register.
- R3: Each off-time keeps `upper_en_o` at 0 for exactly max(`off_cnt_i`,1) cycles. The count used is the one present when the trip is taken.
- R4: An `off_cnt_i` or `blank_cnt_i` value of 0 behaves exactly like 1.
- R5: After each return of `upper_en_o` to 1, the comparator is ignored for max(`blank_cnt_i`,1) cycles. With `trip_i` held high, `upper_en_o` therefore stays 1 for max(`blank_cnt_i`,1)+1 cycles between two off-times.
- R6: A trip seen during an active off-time neither extends nor restarts it (no retrigger).
- R7: When `lin_below_i` is 1 (the linear reference is the smaller one), `lin_mode_o` reads 1 after two rising edges. While it is 1, `upper_en_o` is 1 whatever `trip_i` does, and a running off-time is abandoned.
- R8: `slew_fast_o` is 1 (fast edges) when `lin_mode_o` is 0, and 0 (slow edges) when `lin_mode_o` is 1.
- R9: When `lin_mode_o` falls to 0, a full blanking window runs before a trip is honoured. With `trip_i` held high, `upper_en_o` stays 1 for max(`blank_cnt_i`,1)+1 cycles counted from the first cycle in which `lin_mode_o` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trip_i | input | 1 | Asynchronous over-current flag, 1 = current has reached the target |
| lin_below_i | input | 1 | Asynchronous mode flag, 1 = linear reference below chopping reference |
| off_cnt_i | input | OFF_W | Off-time length in clock cycles (0 treated as 1) |
| blank_cnt_i | input | BLANK_W | Blanking length in clock cycles (0 treated as 1) |
| upper_en_o | output | 1 | 1 = upper driver may conduct, 0 = chopped off |
| lin_mode_o | output | 1 | 1 = linear mode, 0 = chopping mode |
| slew_fast_o | output | 1 | 1 = fast output slew, 0 = slow output slew |

## Verification
A wrong internal state shows up at `upper_en_o`, in the timing of its off and on runs. A stuck or mis-loaded interval counter changes the length of the low run or the high run. That change is visible within one off-time plus one blanking window of the trip. A state machine that leaves blanking too early, or that honours a trip during an off-time, shows a run length that differs from the computed count. An error in the synchronizer or the mode path moves the edge of `lin_mode_o` or `upper_en_o` by a whole cycle away from the second or third edge. The bench samples those exact cycles.

// File: rtl/offtime_chopper_pkg.sv
// Shared types for the fixed off-time chopper.
package offtime_chopper_pkg;
    // Chopper control state: blanking after turn-on, armed for a trip, or chopped off
    typedef enum logic [1:0] {
        ST_BLANK = 2'd0,
        ST_ARMED = 2'd1,
        ST_OFF   = 2'd2
    } chop_state_t;
endpackage

// File: rtl/oc_sync.sv
// Multi-bit flop chain synchronizer for independent asynchronous flags.
// Assumes each bit is a level that stays stable longer than STAGES cycles;
// bits are not coherent with each other. Resets to all zeros.
module oc_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    // Shift the asynchronous levels through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/oc_interval_timer.sv
// Loadable down counter that times one interval of N cycles.
// A load of 0 is clamped to 1. The expired flag is high in the last cycle
// of the interval. Reset loads rst_val, so an interval starts at reset release.
module oc_interval_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] rst_val,
    output logic             expired
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    function automatic logic [CNT_W-1:0] clamp1(input logic [CNT_W-1:0] v);
        return (v == '0) ? ONE : v;
    endfunction

    // Load a new interval or count the current one down to one
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= clamp1(rst_val);
        else if (load)       cnt_q <= clamp1(load_val);
        else if (cnt_q > ONE) cnt_q <= cnt_q - ONE;
    end

    assign expired = (cnt_q == ONE);
endmodule

// File: rtl/offtime_chopper.sv
// Fixed off-time current chopper for the upper drivers of a three-phase stage.
// Chopping mode: a synchronized trip turns the upper driver off for a one-shot
// off-time that cannot be retriggered, and a blanking window follows each turn-on.
// Linear mode (linear reference smaller): no chopping, slow slew requested.
// Assumes off_cnt_i and blank_cnt_i are quasi-static configuration.
module offtime_chopper
    import offtime_chopper_pkg::*;
#(
    parameter int OFF_W       = 8,
    parameter int BLANK_W     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trip_i,
    input  logic               lin_below_i,
    input  logic [OFF_W-1:0]   off_cnt_i,
    input  logic [BLANK_W-1:0] blank_cnt_i,
    output logic               upper_en_o,
    output logic               lin_mode_o,
    output logic               slew_fast_o
);
    localparam int CNT_W = (OFF_W > BLANK_W) ? OFF_W : BLANK_W;

    logic [1:0]       flags_s;
    logic             trip_s;
    logic             lin_s;
    logic [CNT_W-1:0] off_ext;
    logic [CNT_W-1:0] blank_ext;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_load;
    logic             tmr_done;
    chop_state_t      state_q;
    chop_state_t      state_d;

    assign off_ext   = CNT_W'(off_cnt_i);
    assign blank_ext = CNT_W'(blank_cnt_i);

    oc_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({lin_below_i, trip_i}),
        .q     (flags_s)
    );

    assign trip_s = flags_s[0];
    assign lin_s  = flags_s[1];

    oc_interval_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .rst_val  (blank_ext),
        .expired  (tmr_done)
    );

    // Choose the next chopper state and which interval to start
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = blank_ext;
        if (lin_s) begin
            state_d  = ST_BLANK;
            tmr_load = 1'b1;
        end else begin
            unique case (state_q)
                ST_BLANK: if (tmr_done) state_d = ST_ARMED;
                ST_ARMED: if (trip_s) begin
                    state_d  = ST_OFF;
                    tmr_load = 1'b1;
                    tmr_val  = off_ext;
                end
                ST_OFF: if (tmr_done) begin
                    state_d  = ST_BLANK;
                    tmr_load = 1'b1;
                end
                default: begin
                    state_d  = ST_BLANK;
                    tmr_load = 1'b1;
                end
            endcase
        end
    end

    // Hold the chopper state; reset starts in a blanking window
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_BLANK;
        else        state_q <= state_d;
    end

    assign upper_en_o  = lin_s || (state_q != ST_OFF);
    assign lin_mode_o  = lin_s;
    assign slew_fast_o = !lin_s;
endmodule

// File: rtl/offtime_chopper_chk.sv
// Property checker for offtime_chopper, attached by bind.
// Observes ports plus the synchronized flags and the state register.
module offtime_chopper_chk
    import offtime_chopper_pkg::*;
#(
    parameter int OFF_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trip_s,
    input logic             lin_s,
    input chop_state_t      state_q,
    input logic [OFF_W-1:0] off_cnt_i,
    input logic             upper_en_o,
    input logic             lin_mode_o,
    input logic             slew_fast_o
);
    logic [OFF_W-1:0] lim_q;
    logic [OFF_W:0]   run_q;

    // Capture the off-time length at the cycle the trip is taken
    always_ff @(posedge clk) begin
        if (!rst_n) lim_q <= '0;
        else if (state_q == ST_ARMED && trip_s && !lin_s)
            lim_q <= (off_cnt_i == '0) ? OFF_W'(1) : off_cnt_i;
    end

    // Count how many cycles the upper enable has already been low
    always_ff @(posedge clk) begin
        if (!rst_n || upper_en_o) run_q <= '0;
        else if (!(&run_q))       run_q <= run_q + 1'b1;
    end

    p_reset_on_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (upper_en_o && !lin_mode_o && slew_fast_o));

    p_fall_by_trip_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(upper_en_o) |-> ($past(trip_s) && !lin_mode_o));

    p_off_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !upper_en_o |-> (run_q < {1'b0, lim_q}));

    p_blank_ignore_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(upper_en_o) |-> ($past(state_q) == ST_ARMED));

    p_lin_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lin_mode_o |-> upper_en_o);

    p_slew_r8: assert property (@(posedge clk) disable iff (!rst_n)
        slew_fast_o != lin_mode_o);

    p_exit_blank_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lin_mode_o) |-> (state_q == ST_BLANK));
endmodule

bind offtime_chopper offtime_chopper_chk #(
    .OFF_W (OFF_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .trip_s      (trip_s),
    .lin_s       (lin_s),
    .state_q     (state_q),
    .off_cnt_i   (off_cnt_i),
    .upper_en_o  (upper_en_o),
    .lin_mode_o  (lin_mode_o),
    .slew_fast_o (slew_fast_o)
);

// File: tb/offtime_chopper_tb.sv
// Directed bench: one task per scenario, inputs driven and outputs sampled on
// the falling clock edge.
module offtime_chopper_tb;
    localparam int OFF_W   = 8;
    localparam int BLANK_W = 8;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               trip_i = 1'b0;
    logic               lin_below_i = 1'b0;
    logic [OFF_W-1:0]   off_cnt_i = 8'd5;
    logic [BLANK_W-1:0] blank_cnt_i = 8'd4;
    logic               upper_en_o;
    logic               lin_mode_o;
    logic               slew_fast_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    offtime_chopper #(
        .OFF_W   (OFF_W),
        .BLANK_W (BLANK_W)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .trip_i      (trip_i),
        .lin_below_i (lin_below_i),
        .off_cnt_i   (off_cnt_i),
        .blank_cnt_i (blank_cnt_i),
        .upper_en_o  (upper_en_o),
        .lin_mode_o  (lin_mode_o),
        .slew_fast_o (slew_fast_o)
    );

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input int off, input int blank);
        @(negedge clk);
        rst_n = 1'b0;
        trip_i = 1'b0;
        lin_below_i = 1'b0;
        off_cnt_i = OFF_W'(off);
        blank_cnt_i = BLANK_W'(blank);
        tick(3);
        rst_n = 1'b1;
    endtask

    // Count consecutive samples (current one included) at the given level
    task automatic run_len(input logic lvl, output int n);
        n = 0;
        while (upper_en_o == lvl && n < 1000) begin
            n++;
            tick();
        end
    endtask

    // Advance until upper_en_o reads the given level, at most 200 samples
    task automatic wait_level(input logic lvl);
        for (int i = 0; i < 200 && upper_en_o != lvl; i++) tick();
    endtask

    task automatic pulse_trip();
        trip_i = 1'b1;
        tick();
        trip_i = 1'b0;
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        rst_n = 1'b0;
        tick(2);
        check_eq("R1", "upper_en in reset", upper_en_o, 1);
        check_eq("R1", "lin_mode in reset", lin_mode_o, 0);
        check_eq("R1", "slew_fast in reset", slew_fast_o, 1);
        do_reset(5, 4);
        tick();
        check_eq("R1", "upper_en after release", upper_en_o, 1);
    endtask

    task automatic t_blank_after_reset();
        int lows = 0;
        int k = 0;
        // short pulse inside the reset blanking window must be ignored (R5)
        do_reset(5, 8);
        pulse_trip();
        for (int i = 0; i < 20; i++) begin
            if (!upper_en_o) lows++;
            tick();
        end
        check_eq("R5", "low samples for pulse in blanking", lows, 0);
        // held trip from release: first low after edge blank+1 (R1)
        do_reset(5, 8);
        trip_i = 1'b1;
        while (upper_en_o && k < 100) begin
            tick();
            k++;
        end
        check_eq("R1", "edges until first off after reset", k, 9);
        trip_i = 1'b0;
    endtask

    task automatic t_trip_latency();
        int n;
        do_reset(5, 2);
        tick(10);
        pulse_trip();
        check_eq("R2", "upper_en after edge 1", upper_en_o, 1);
        tick();
        check_eq("R2", "upper_en after edge 2", upper_en_o, 1);
        tick();
        check_eq("R2", "upper_en after edge 3", upper_en_o, 0);
        run_len(1'b0, n);
        check_eq("R3", "off length for count 5", n, 5);
    endtask

    task automatic t_off_len(input int off, input int exp, input string req);
        int n;
        do_reset(off, 2);
        tick(10);
        pulse_trip();
        wait_level(1'b0);
        run_len(1'b0, n);
        check_eq(req, "off length", n, exp);
    endtask

    task automatic t_held(input int off, input int blank, input string req);
        int l1, h, l2;
        int eo = (off == 0) ? 1 : off;
        int eb = (blank == 0) ? 1 : blank;
        do_reset(off, blank);
        tick(10);
        trip_i = 1'b1;
        wait_level(1'b0);
        run_len(1'b0, l1);
        run_len(1'b1, h);
        run_len(1'b0, l2);
        trip_i = 1'b0;
        check_eq("R6", {req, " first off with trip held"}, l1, eo);
        check_eq("R5", {req, " on run between off-times"}, h, eb + 1);
        check_eq("R6", {req, " second off with trip held"}, l2, eo);
    endtask

    task automatic t_linear();
        int lows = 0;
        do_reset(40, 2);
        tick(10);
        pulse_trip();
        wait_level(1'b0);
        lin_below_i = 1'b1;
        tick();
        check_eq("R7", "lin_mode after one edge", lin_mode_o, 0);
        check_eq("R7", "still off after one edge", upper_en_o, 0);
        tick();
        check_eq("R7", "lin_mode after two edges", lin_mode_o, 1);
        check_eq("R7", "off-time abandoned", upper_en_o, 1);
        check_eq("R8", "slow slew in linear", slew_fast_o, 0);
        trip_i = 1'b1;
        for (int i = 0; i < 60; i++) begin
            tick();
            if (!upper_en_o) lows++;
        end
        check_eq("R7", "low samples with trip in linear", lows, 0);
        trip_i = 1'b0;
        lin_below_i = 1'b0;
    endtask

    task automatic t_lin_exit(input int blank, input string req);
        int h, l;
        int eb = (blank == 0) ? 1 : blank;
        do_reset(3, blank);
        lin_below_i = 1'b1;
        trip_i = 1'b1;
        tick(10);
        check_eq("R7", {req, " on in linear with trip"}, upper_en_o, 1);
        lin_below_i = 1'b0;
        tick();
        check_eq("R9", {req, " lin_mode one edge after drop"}, lin_mode_o, 1);
        tick();
        check_eq("R9", {req, " lin_mode two edges after drop"}, lin_mode_o, 0);
        check_eq("R8", {req, " fast slew back in chopping"}, slew_fast_o, 1);
        run_len(1'b1, h);
        check_eq("R9", {req, " on run after leaving linear"}, h, eb + 1);
        run_len(1'b0, l);
        check_eq("R3", {req, " off length after leaving linear"}, l, 3);
        trip_i = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset_state();
        t_blank_after_reset();
        t_trip_latency();
        t_off_len(1, 1, "R3");
        t_off_len(0, 1, "R4");
        t_off_len(17, 17, "R3");
        t_held(3, 4, "held 3/4");
        t_held(0, 0, "held zero R4");
        t_held(6, 1, "held 6/1");
        t_linear();
        t_lin_exit(5, "exit 5");
        t_lin_exit(0, "exit zero R4");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule